// File: doc/BRIEF.md
# Prescaled 8-bit backlight PWM

A single-channel pulse-width modulator meant to dim a display backlight. Software writes a 16-bit configuration word holding an 8-bit compare value, a polarity flag and a 3-bit power-of-two prescaler code. It then starts and stops the channel with separate one-cycle start and stop strobes, and reads a status output that says whether the channel is running.

Each period is 256 prescaled ticks long. The output is active while an 8-bit period counter is below the compare value, so duty runs from 0/256 up to 255/256 and can never reach a full period. The tick source is either every cycle of the block clock (fast source) or a single-cycle slow tick pulse from elsewhere in the chip. A level input picks between the two.

Configuration changes made while the channel runs are held back until the counter wraps, which keeps the waveform free of glitches. While stopped, the counters are held at zero and the output rests at the inactive level of the configured polarity.

Top module: `bl_pwm`

## Requirements
- R1: After reset `running` is 0 and the configuration word is 0x0010 (compare 0, polarity 1, prescaler code 0), so `pwm_out` is 0.
- R2: The configuration word carries the compare value in bits 15:8, the polarity flag in bit 4 and the prescaler code in bits 2:0. Other bits are ignored.
- R3: Prescaler code p makes one counter step take 2^p source ticks, so a period takes 256·2^p source ticks. Code 7 behaves exactly as code 6.
- R4: In each period the output is active for compare·2^p source ticks, starting at the period start. Compare 0 gives no active level at all.
- R5: With polarity 1 the active level is high. With polarity 0 the waveform is inverted, so the active level is low.
- R6: With `src_fast`=1 every clock cycle is a source tick. With `src_fast`=0 only cycles with `slow_tick`=1 are source ticks.
- R7: A `start_stb` pulse from the stopped state sets `running` on the next clock and begins a period from counter 0. A `start_stb` while running does not disturb the waveform.
- R8: A `stop_stb` pulse clears `running` on the next clock and wins over a simultaneous `start_stb`. While stopped, `pwm_out` holds the inactive level (the inverse of the configured polarity).
- R9: Configuration written while running takes effect only at the next period boundary, when the counter wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fast tick source |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_fast | input | 1 | Tick source select: 1 = every clock, 0 = slow tick |
| slow_tick | input | 1 | Single-cycle slow tick pulse |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word |
| start_stb | input | 1 | Write-one start strobe |
| stop_stb | input | 1 | Write-one stop strobe |
| running | output | 1 | Channel status |
| pwm_out | output | 1 | Modulated output |

## Verification
On every cycle the assertions check the strobe handshake: status one clock after start or stop, stop winning when both arrive, and counters at zero on start. They also check that the output sits at the inactive level whenever the channel is stopped or the compare value is zero, that the applied settings never move except at a wrap, and that the prescale divider stays within range. Only the bench's scenarios can show the waveform as a whole. It counts active cycles over whole periods for random compare, polarity and prescaler settings, checks that code 7 saturates, measures duty under the slow tick source, and confirms that a mid-period write only shows up in the following period.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int          PS_MAX  = 6,
  parameter logic [15:0] CFG_RST = 16'h0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_fast,
  input  logic        slow_tick,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic        start_stb,
  input  logic        stop_stb,
  output logic        running,
  output logic        pwm_out
);
  localparam int DIVW = (PS_MAX < 1) ? 1 : PS_MAX;

  logic [15:0]     cfg_q;
  logic [7:0]      cmp_a, cnt;
  logic            pol_a;
  logic [2:0]      ps_a;
  logic [DIVW-1:0] div, div_mask;
  logic            run_nx, tick, ptick, wrap, on;

  wire [2:0] ps_sat = (cfg_q[2:0] > 3'(PS_MAX)) ? 3'(PS_MAX) : cfg_q[2:0];

  assign run_nx   = stop_stb ? 1'b0 : (start_stb ? 1'b1 : running);
  assign tick     = src_fast ? 1'b1 : slow_tick;
  assign div_mask = ~({DIVW{1'b1}} << ps_a);
  assign ptick    = running & tick & ((div & div_mask) == div_mask);
  assign wrap     = ptick & (cnt == 8'hFF);
  assign on       = running & (cnt < cmp_a);
  assign pwm_out  = pol_a ? on : ~on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      running <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      running <= run_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= CFG_RST[15:8];
      pol_a <= CFG_RST[4];
      ps_a  <= 3'd0;
    end else if (!running || wrap) begin
      cmp_a <= cfg_q[15:8];
      pol_a <= cfg_q[4];
      ps_a  <= ps_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      cnt <= 8'd0;
    end else if (!running || !run_nx) begin
      div <= '0;
      cnt <= 8'd0;
    end else if (tick) begin
      if (ptick) begin
        div <= '0;
        cnt <= cnt + 8'd1;
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start_stb && !stop_stb) |=> (running && cnt == 8'd0 && div == '0));
  p_stop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> (!running && cnt == 8'd0));
  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_out == !pol_a));
  p_zero_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_a == 8'd0) |-> (pwm_out == !pol_a));
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |=> ($stable(cmp_a) && $stable(pol_a) && $stable(ps_a)));
  p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div <= div_mask) && (ps_a <= 3'(PS_MAX)));
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ptick && !stop_stb) |=> $stable(cnt));
endmodule

// File: tb/sim_bl_pwm.sv
`timescale 1ns/1ps
module sim_bl_pwm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic src_fast = 1'b1, slow_tick = 1'b0, cfg_we = 1'b0;
  logic [15:0] cfg_wdata = 16'h0;
  logic start_stb = 1'b0, stop_stb = 1'b0;
  logic running, pwm_out;
  int checks = 0, fails = 0, ph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bl_pwm u0 (.clk(clk), .rst_n(rst_n), .src_fast(src_fast), .slow_tick(slow_tick),
             .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .start_stb(start_stb),
             .stop_stb(stop_stb), .running(running), .pwm_out(pwm_out));

  always @(negedge clk) begin
    ph <= (ph == 2) ? 0 : ph + 1;
    slow_tick <= (ph == 1);
  end

  function automatic int sat(int p); return (p > 6) ? 6 : p; endfunction
  function automatic int period_of(int p); return 256 << sat(p); endfunction
  function automatic int exp_active(int cmp, int p); return cmp << sat(p); endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(int cmp, bit pol, int ps);
    cfg_we = 1'b1;
    cfg_wdata = {8'(cmp), 3'b111, pol, 1'b1, 3'(ps)} & 16'hFF17;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start();
    start_stb = 1'b1; @(negedge clk); start_stb = 1'b0;
  endtask

  task automatic stop();
    stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0;
  endtask

  task automatic measure(int n, bit pol, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out == pol) c++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(int cmp, bit pol, int ps, string tag);
    int c;
    cfg_write(cmp, pol, ps);
    @(negedge clk);
    chk(pwm_out == !pol, {tag, " R8 idle level"}, pwm_out, !pol);
    start();
    chk(running == 1'b1, {tag, " R7 running"}, running, 1);
    measure(period_of(ps), pol, c);
    chk(c == exp_active(cmp, ps), {tag, " R2 R3 R4 R5 active count"}, c, exp_active(cmp, ps));
    chk((pwm_out == pol) == (cmp > 0), {tag, " R3 next period start"}, pwm_out, (cmp > 0) ? pol : !pol);
    stop();
    chk(running == 1'b0, {tag, " R8 stopped"}, running, 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c1, c2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(running == 1'b0, "R1 reset status", running, 0);
    chk(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 output after release", pwm_out, 0);

    run_case(0, 1'b1, 2, "zero cmp");
    run_case(255, 1'b0, 1, "full cmp");
    run_case(100, 1'b1, 7, "code7 saturate");
    for (int k = 0; k < 8; k++)
      run_case(int'($urandom % 256), 1'($urandom), int'($urandom % 5), "random");

    src_fast = 1'b0;
    cfg_write(77, 1'b1, 0);
    start();
    measure(768, 1'b1, c1);
    chk(c1 == 77 * 3, "R6 slow source duty", c1, 77 * 3);
    stop();
    src_fast = 1'b1;
    @(negedge clk);
    chk(running == 1'b0, "R6 stopped", running, 0);

    cfg_write(60, 1'b1, 1);
    start();
    c1 = 0; c2 = 0;
    for (int i = 0; i < 1024; i++) begin
      if (pwm_out == 1'b1) begin
        if (i < 512) c1++; else c2++;
      end
      cfg_we = (i == 10);
      cfg_wdata = {8'd200, 8'h11};
      start_stb = (i == 20);
      @(negedge clk);
    end
    cfg_we = 1'b0; start_stb = 1'b0;
    chk(c1 == 120, "R9 old setting kept this period", c1, 120);
    chk(c2 == 400, "R9 new setting next period", c2, 400);
    chk(running == 1'b1, "R7 start while running", running, 1);

    start_stb = 1'b1; stop_stb = 1'b1;
    @(negedge clk);
    start_stb = 1'b0; stop_stb = 1'b0;
    chk(running == 1'b0, "R8 stop wins while running", running, 0);
    start_stb = 1'b1; stop_stb = 1'b1;
    @(negedge clk);
    start_stb = 1'b0; stop_stb = 1'b0;
    chk(running == 1'b0, "R8 stop wins while stopped", running, 0);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R8 idle level polarity 1", pwm_out, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule